// File: doc/BRIEF.md
# UART receiver with standby wakeup

This block is the receive half of an asynchronous serial port. A 16x sample tick is derived from the system clock, and the block hunts for a falling edge on the synchronised line. It confirms the start bit at mid-bit and decides every bit by a two-of-three vote. It then delivers an 8-bit or 9-bit character, least significant bit first, together with a one-clock data-ready strobe. It also reports an idle line: one full character time of continuous high level after the last character.

Software can place the receiver in standby. While in standby, received characters and idle periods produce no strobes. Hardware leaves standby by itself when the selected wakeup event is seen. In idle-line mode that event is an idle line following a message. In address-mark mode it is a character whose top data bit is 1, and that character is delivered. This lets a node on a shared line ignore traffic addressed to other nodes.

Top module: `uart_rx_wakeup`

## Requirements
- R1: With `rx_en` low the receiver ignores `rxd`: `rx_valid` and `idle_det` stay 0, and the character in progress is abandoned.
- R2: With `len9`=0 a frame is one low start bit, 8 data bits sent LSB first, then a high stop bit. The character appears on `rx_data[7:0]` with `rx_data[8]`=0, and `rx_valid` pulses for one clock.
- R3: With `len9`=1 the frame carries 9 data bits, LSB first, delivered on `rx_data[8:0]`.
- R4: Each bit is decided by a majority of the line samples at ticks 7, 8 and 9 of its 16 ticks. A disturbance lasting one tick does not change the received value.
- R5: A low level that is no longer low at mid-bit is rejected as a start bit. No character results, and the receiver returns to hunting.
- R6: After a character, `idle_det` pulses once when the line has stayed high for 10 bit times (8-bit mode). It does not pulse again until a new start bit is accepted.
- R7: Writing `sby_wdata`=1 with `sby_wr` sets `standby`, and writing 0 clears it. `standby` is 0 after reset, and a write takes precedence over a hardware clear in the same cycle.
- R8: In standby with `wake_sel`=0 (idle-line mode), characters are discarded. The next idle line clears `standby` without pulsing `idle_det`.
- R9: In standby with `wake_sel`=1 (address-mark mode), characters whose top data bit (bit 7, or bit 8 when `len9`=1) is 0 are discarded. The first character with that bit at 1 clears `standby` and is delivered with `rx_valid`.
- R10: In address-mark standby an idle line neither clears `standby` nor pulses `idle_det`.
- R11: With `len9`=1 the idle threshold is 11 bit times instead of 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| rx_en | input | 1 | Receiver enable |
| sby_wr | input | 1 | Write strobe for the standby bit |
| sby_wdata | input | 1 | Value written to the standby bit |
| wake_sel | input | 1 | Wakeup method: 0 idle line, 1 address mark |
| len9 | input | 1 | Character length: 0 eight bits, 1 nine bits |
| rx_data | output | 9 | Last delivered character |
| rx_valid | output | 1 | One-clock strobe for a delivered character |
| idle_det | output | 1 | One-clock strobe for a detected idle line |
| standby | output | 1 | Standby state |

## Verification
The bench builds the block with `TICK_DIV`=2, so a bit lasts 32 clocks and a frame about 320. This short bit time keeps the run brief while the idle timing can still be tested. It is long enough that the bench can place windows between the 10- and 11-bit idle thresholds. It can also insert a one-tick glitch that lands inside the 7-to-9 voting window.

// File: rtl/uart_rx_wakeup.sv
`timescale 1ns/1ps
module uart_rx_wakeup #(
  parameter int TICK_DIV = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       rx_en,
  input  logic       sby_wr,
  input  logic       sby_wdata,
  input  logic       wake_sel,
  input  logic       len9,
  output logic [8:0] rx_data,
  output logic       rx_valid,
  output logic       idle_det,
  output logic       standby
);

  localparam int DW     = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int IDLE_8 = 10 * 16;
  localparam int IDLE_9 = 11 * 16;

  typedef enum logic [1:0] {HUNT, START, DATA, STOP} st_t;

  logic [DW-1:0] div_q;
  logic          tick;
  logic          rx_m, rx_s, prev_hi;
  st_t           st;
  logic [3:0]    ph, nph, bidx;
  logic          v7, v8, bitv, mid;
  logic [8:0]    sh;
  logic [7:0]    icnt, thr;
  logic          idle_done, idle_hit, char_done, msb, wake;

  assign tick = (div_q == DW'(TICK_DIV - 1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                div_q <= '0;
    else if (!rx_en || tick)   div_q <= '0;
    else                       div_q <= div_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rxd;
      rx_s <= rx_m;
    end

  assign nph       = ph + 4'd1;
  assign bitv      = (v7 & v8) | (v7 & rx_s) | (v8 & rx_s);
  assign mid       = tick && (nph == 4'd9);
  assign thr       = len9 ? 8'(IDLE_9 - 1) : 8'(IDLE_8 - 1);
  assign idle_hit  = rx_en && (st == HUNT) && tick && rx_s && prev_hi && !idle_done && (icnt == thr);
  assign char_done = rx_en && (st == STOP) && mid;
  assign msb       = len9 ? sh[8] : sh[7];
  assign wake      = standby && (wake_sel ? (char_done && msb) : idle_hit);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st        <= HUNT;
      ph        <= '0;
      bidx      <= '0;
      v7        <= 1'b1;
      v8        <= 1'b1;
      sh        <= '0;
      icnt      <= '0;
      idle_done <= 1'b0;
      prev_hi   <= 1'b0;
    end else if (!rx_en) begin
      st        <= HUNT;
      ph        <= '0;
      icnt      <= '0;
      idle_done <= 1'b0;
      prev_hi   <= 1'b0;
    end else if (tick) begin
      prev_hi <= rx_s;
      if (st != HUNT) begin
        ph <= nph;
        if (nph == 4'd7) v7 <= rx_s;
        if (nph == 4'd8) v8 <= rx_s;
      end
      case (st)
        HUNT: begin
          if (!rx_s && prev_hi) begin
            st   <= START;
            ph   <= 4'd1;
            icnt <= '0;
          end else if (!rx_s) begin
            icnt <= '0;
          end else if (!idle_done) begin
            if (idle_hit) idle_done <= 1'b1;
            else if (prev_hi) icnt <= icnt + 8'd1;
          end
        end
        START: if (nph == 4'd9) begin
          if (!bitv) begin
            st        <= DATA;
            bidx      <= '0;
            sh        <= '0;
            idle_done <= 1'b0;
          end else begin
            st <= HUNT;
          end
        end
        DATA: if (nph == 4'd9) begin
          sh[bidx] <= bitv;
          if (bidx == (len9 ? 4'd8 : 4'd7)) st <= STOP;
          else bidx <= bidx + 4'd1;
        end
        STOP: if (nph == 4'd9) begin
          st   <= HUNT;
          icnt <= '0;
        end
        default: st <= HUNT;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_valid <= 1'b0;
      idle_det <= 1'b0;
      rx_data  <= '0;
      standby  <= 1'b0;
    end else begin
      rx_valid <= char_done && (!standby || (wake_sel && msb));
      idle_det <= idle_hit && !standby;
      if (char_done && (!standby || (wake_sel && msb))) rx_data <= sh;
      if (sby_wr)    standby <= sby_wdata;
      else if (wake) standby <= 1'b0;
    end

  // R1
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_valid && !idle_det));

  // R8
  idle_standby_mute_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (standby && !wake_sel && !sby_wr) |=> !rx_valid);

  // R10
  standby_no_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !idle_det);

  // R7
  standby_set_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(standby) |-> $past(sby_wr && sby_wdata));

  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sby_wr |=> (standby == $past(sby_wdata)));

  // R6
  strobes_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid && idle_det));

endmodule

// File: tb/uart_rx_wakeup_tb_top.sv
`timescale 1ns/1ps
module uart_rx_wakeup_tb_top;

  logic clk = 1'b0, rst_n = 1'b0, rxd = 1'b1, rx_en = 1'b0;
  logic sby_wr = 1'b0, sby_wdata = 1'b0, wake_sel = 1'b0, len9 = 1'b0;
  logic [8:0] rx_data;
  logic rx_valid, idle_det, standby;

  int nchk = 0, nfail = 0, nval = 0, nidle = 0;
  logic [8:0] last = '0;
  bit done = 1'b0;

  localparam int BIT = 32;

  // {len9, sent data, expected rx_data}
  localparam logic [18:0] VEC [7] = '{
    {1'b0, 9'h055, 9'h055}, {1'b0, 9'h100, 9'h000}, {1'b0, 9'h1FF, 9'h0FF},
    {1'b0, 9'h0A3, 9'h0A3}, {1'b1, 9'h1A5, 9'h1A5}, {1'b1, 9'h0FF, 9'h0FF},
    {1'b1, 9'h100, 9'h100}};

  always #2.5 clk = ~clk;

  uart_rx_wakeup #(.TICK_DIV(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rx_en(rx_en), .sby_wr(sby_wr),
    .sby_wdata(sby_wdata), .wake_sel(wake_sel), .len9(len9), .rx_data(rx_data),
    .rx_valid(rx_valid), .idle_det(idle_det), .standby(standby));

  always @(posedge clk) begin
    if (rx_valid) begin nval <= nval + 1; last <= rx_data; end
    if (idle_det) nidle <= nidle + 1;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr();
    nval = 0; nidle = 0;
  endtask

  // glitch_bit >= 0 inverts the line for 2 clocks in the middle of that data bit
  task automatic send(input logic [8:0] d, input bit nine, input int glitch_bit);
    int nb;
    nb = nine ? 9 : 8;
    rxd = 1'b0; wclk(BIT);
    for (int i = 0; i < nb; i++) begin
      rxd = d[i];
      if (i == glitch_bit) begin
        wclk(15); rxd = ~d[i]; wclk(2); rxd = d[i]; wclk(BIT - 17);
      end else wclk(BIT);
    end
    rxd = 1'b1; wclk(BIT);
  endtask

  task automatic wr_sby(input logic v);
    sby_wdata = v; sby_wr = 1'b1; wclk(1); sby_wr = 1'b0; wclk(1);
  endtask

  initial begin
    wclk(3);
    check(rx_valid == 0 && idle_det == 0 && standby == 0 && rx_data == 0, "R7 reset", {rx_valid, idle_det, standby}, 0);
    rst_n = 1'b1; wclk(2);

    // R1: disabled receiver
    clr(); send(9'h05A, 1'b0, -1); wclk(400);
    check(nval == 0, "R1 no data while off", nval, 0);
    check(nidle == 0, "R1 no idle while off", nidle, 0);

    rx_en = 1'b1; wclk(450); clr();

    // R2/R3 vector table
    foreach (VEC[k]) begin
      len9 = VEC[k][18]; clr();
      send(VEC[k][17:9], VEC[k][18], -1); wclk(4);
      check(nval == 1, VEC[k][18] ? "R3 count" : "R2 count", nval, 1);
      check(last == VEC[k][8:0], VEC[k][18] ? "R3 data" : "R2 data", last, VEC[k][8:0]);
    end
    // R11: 9-bit idle threshold
    clr(); wclk(316);
    check(nidle == 0, "R11 not before 11 bits", nidle, 0);
    wclk(60);
    check(nidle == 1, "R11 idle at 11 bits", nidle, 1);

    // R6: 8-bit idle once
    len9 = 1'b0; send(9'h03C, 1'b0, -1); clr(); wclk(286);
    check(nidle == 0, "R6 not before 10 bits", nidle, 0);
    wclk(40);
    check(nidle == 1, "R6 idle at 10 bits", nidle, 1);
    wclk(500);
    check(nidle == 1, "R6 idle only once", nidle, 1);

    // R4: single-tick glitches
    clr(); send(9'h000, 1'b0, 3); wclk(4);
    check(nval == 1 && last == 9'h000, "R4 high glitch", last, 0);
    clr(); send(9'h0FF, 1'b0, 5); wclk(4);
    check(nval == 1 && last == 9'h0FF, "R4 low glitch", last, 9'h0FF);

    // R5: false start
    clr(); rxd = 1'b0; wclk(6); rxd = 1'b1; wclk(100);
    check(nval == 0, "R5 short low rejected", nval, 0);
    send(9'h081, 1'b0, -1); wclk(4);
    check(nval == 1 && last == 9'h081, "R5 recovers", last, 9'h081);
    wclk(400);

    // R7: write set/clear
    wr_sby(1'b1);
    check(standby == 1, "R7 set", standby, 1);
    wr_sby(1'b0);
    check(standby == 0, "R7 clear", standby, 0);

    // R8: idle-line wakeup
    wake_sel = 1'b0; wr_sby(1'b1); clr();
    send(9'h0F0, 1'b0, -1); send(9'h011, 1'b0, -1); wclk(4);
    check(nval == 0, "R8 discarded", nval, 0);
    check(standby == 1, "R8 still standby", standby, 1);
    wclk(400);
    check(standby == 0, "R8 idle wakes", standby, 0);
    check(nidle == 0, "R8 no idle strobe", nidle, 0);
    send(9'h066, 1'b0, -1); wclk(4);
    check(nval == 1 && last == 9'h066, "R8 normal after wake", last, 9'h066);
    wclk(400);

    // R9/R10: address-mark wakeup
    wake_sel = 1'b1; wr_sby(1'b1); clr();
    send(9'h012, 1'b0, -1); wclk(4);
    check(nval == 0 && standby == 1, "R9 msb0 discarded", nval, 0);
    wclk(400);
    check(standby == 1, "R10 idle no wake", standby, 1);
    check(nidle == 0, "R10 no idle strobe", nidle, 0);
    send(9'h085, 1'b0, -1); wclk(4);
    check(nval == 1 && last == 9'h085, "R9 address delivered", last, 9'h085);
    check(standby == 0, "R9 wake", standby, 0);
    len9 = 1'b1; wr_sby(1'b1); clr();
    send(9'h0FF, 1'b1, -1); wclk(4);
    check(nval == 0 && standby == 1, "R9 nine-bit msb0 discarded", nval, 0);
    send(9'h100, 1'b1, -1); wclk(4);
    check(nval == 1 && last == 9'h100 && standby == 0, "R9 nine-bit wake", last, 9'h100);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

endmodule